// File: doc/BRIEF.md
# Pipelined Burst SRAM Access Controller

This block is the control and storage core of a small synchronous pipelined SRAM with a common 32-bit data path and a 17-bit word address. Every input is taken at the rising clock edge. Three chip enables decide whether the device is selected. An access starts from one of two address strobes: the processor strobe or the controller strobe. Later cycles of a burst step a two-bit wraparound offset, in either interleaved order or linear order. Writes cover all four bytes or only the bytes selected per lane. Read data comes out of an output register one clock after the address is captured.

The two strobes start writes differently. A processor-strobe access always opens as a read, and its write happens on the following edge. A controller-strobe access with its write inputs active finishes the write in that same cycle. The data bus is split into separate in and out ports plus a drive enable. The drive enable is a registered flag gated by the asynchronous output enable. It is held low in four cases: during writes, on deselect, on the first read after a deselected state, and while the sleep input is in effect. The storage array is a parameterised register array indexed by the low address bits.

Top module: `sram_burst_ctrl`

## Requirements
- R1: The device is selected only when ce1_ni=0, ce2_i=1 and ce3_ni=0 at the edge. A strobe edge with the device not selected is a deselect. The processor strobe is not recognised while ce1_ni=1.
- R2: A recognised processor-strobe start is always a read, and the write inputs are ignored at that edge. Write inputs at the next edge with no strobe and adv_ni=1 write the same address.
- R3: A controller-strobe start (processor strobe not recognised) with active write inputs writes the captured address at that edge. adv_ni is ignored on that edge.
- R4: gw_ni=0 writes all four bytes. Otherwise, with bwe_ni=0, byte lane k (bits 8k+7:8k) is written only when bw_ni[k]=0. With gw_ni=1, and either bwe_ni=1 or bw_ni=4'hF, the cycle is a read. Bytes that are not written keep their old contents.
- R5: rdata_o holds the word at the accessed address from the edge after the read edge.
- R6: drive_o equals the registered drive flag ANDed with oe_ni=0. After a deselect edge, drive_o is 0.
- R7: After any write edge, drive_o is 0.
- R8: The first read edge after a deselected, reset or sleep state leaves drive_o at 0. The next read edge, with the device still active, sets it to 1.
- R9: Burst offset = first ^ count when linear_i=0, and (first + count) mod 4 when linear_i=1. count starts at 0. With no strobe, adv_ni=0 increments count and adv_ni=1 holds it. The offset replaces address bits 1:0.
- R10: sleep_i takes effect from the third edge after it rises. While it is in effect, all inputs are ignored, drive_o is 0 and memory contents are kept. Accesses resume from the third edge after it falls, and the first read after that is masked as in R8.
- R11: When both strobes are low with ce1_ni=0, only the processor strobe counts, so the access is a read.
- R12: Reset makes rdata_o 0, makes drive_o 0 and leaves the device deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 17 | Word address |
| ce1_ni | input | 1 | Chip enable 1, active low; also gates the processor strobe |
| ce2_i | input | 1 | Chip enable 2, active high |
| ce3_ni | input | 1 | Chip enable 3, active low |
| adsp_ni | input | 1 | Processor address strobe, active low |
| adsc_ni | input | 1 | Controller address strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| gw_ni | input | 1 | Global write, active low |
| bwe_ni | input | 1 | Byte write enable, active low |
| bw_ni | input | 4 | Per-lane byte selects, active low |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Sleep request, active high |
| linear_i | input | 1 | Burst order: 1 linear, 0 interleaved |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| drive_o | output | 1 | Data bus drive enable |

## Verification
The bench builds the block with MEM_AW=5, which gives a 32-word array, and keeps the default data and address widths. The small depth lets one four-word group be filled and then walked in both burst orders, forward and wrapping. It also lets every stored word be compared against a bench-side copy after byte writes, bursts and a sleep period. With the full 17-bit address port still present, the same run covers strobe priority, deselect, the drive mask on the first read, and the gating by the output enable.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_DESEL = 2'd3
  } op_e;
endpackage

// File: rtl/burst_offset_ctr.sv
module burst_offset_ctr #(
  parameter int unsigned CW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          adv_i,
  input  logic          linear_i,
  input  logic [CW-1:0] seed_i,
  output logic [CW-1:0] off_o
);
  logic [CW-1:0] seed_q, cnt_q, seed_e, cnt_e;

  always_comb begin
    seed_e = load_i ? seed_i : seed_q;
    cnt_e  = load_i ? '0 : (adv_i ? cnt_q + 1'b1 : cnt_q);
    off_o  = linear_i ? seed_e + cnt_e : seed_e ^ cnt_e;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seed_q <= '0;
      cnt_q  <= '0;
    end else begin
      seed_q <= seed_e;
      cnt_q  <= cnt_e;
    end
  end

  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  // R9: idle cycle holds the offset
  a_r9_hold_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !load_i && !adv_i && $stable(linear_i)) |-> off_o == $past(off_o));
  // R9: linear step adds one, wrapping
  a_r9_linear_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !load_i && adv_i && linear_i && $past(linear_i))
      |-> off_o == CW'($past(off_o) + 1'b1));
endmodule

// File: rtl/lane_ram.sv
module lane_ram #(
  parameter int unsigned AW     = 6,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [AW-1:0]           addr_i,
  input  logic [LANES-1:0]        we_i,
  input  logic                    re_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem_q [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk_i) begin
      if (we_i[g]) mem_q[addr_i] <= wdata_i[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   rd_q <= '0;
      else if (re_i) rd_q <= mem_q[addr_i];
    end

    assign rdata_o[g*LANE_W +: LANE_W] = rd_q;
  end

  // R5: the output register changes only on a read edge
  a_r5_rdata_only_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));
endmodule

// File: rtl/sram_burst_ctrl.sv
module sram_burst_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W  = 17,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned MEM_AW  = 6,
  parameter int unsigned BURST_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ce1_ni,
  input  logic              ce2_i,
  input  logic              ce3_ni,
  input  logic              adsp_ni,
  input  logic              adsc_ni,
  input  logic              adv_ni,
  input  logic              gw_ni,
  input  logic              bwe_ni,
  input  logic [3:0]        bw_ni,
  input  logic              oe_ni,
  input  logic              sleep_i,
  input  logic              linear_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              drive_o
);
  localparam int unsigned LANE_W = 8;
  localparam int unsigned LANES  = DATA_W / LANE_W;
  localparam int unsigned BASE_W = ADDR_W - BURST_W;

  logic [1:0]         slp_q;
  logic               sleeping, sel, p_strobe, strobe;
  logic               p_start, c_start, start, cont;
  logic               active_q, drv_q;
  logic [LANES-1:0]   lane_req, lane_we;
  logic               wr_any;
  op_e                op;
  logic [BASE_W-1:0]  base_q, base_e;
  logic [BURST_W-1:0] off;
  logic [ADDR_W-1:0]  full_addr;

  assign sleeping = slp_q[1];
  assign sel      = !ce1_ni && ce2_i && !ce3_ni;
  assign p_strobe = !adsp_ni && !ce1_ni;   // processor strobe masked by ce1
  assign strobe   = p_strobe || !adsc_ni;
  assign p_start  = !sleeping && p_strobe && sel;
  assign c_start  = !sleeping && !p_strobe && !adsc_ni && sel;
  assign start    = p_start || c_start;
  assign cont     = !sleeping && !strobe && active_q;

  always_comb begin
    if (!gw_ni)       lane_req = '1;
    else if (!bwe_ni) lane_req = ~bw_ni[LANES-1:0];
    else              lane_req = '0;
    wr_any = |lane_req;

    if (sleeping)                           op = OP_NONE;
    else if (strobe && !sel)                op = OP_DESEL;
    else if (p_start)                       op = OP_READ;   // write ignored
    else if ((c_start || cont) && wr_any)   op = OP_WRITE;
    else if (c_start || cont)               op = OP_READ;
    else                                    op = OP_NONE;

    lane_we = (op == OP_WRITE) ? lane_req : '0;
  end

  assign base_e    = start ? addr_i[ADDR_W-1:BURST_W] : base_q;
  assign full_addr = {base_e, off};

  burst_offset_ctr #(.CW(BURST_W)) u_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (start),
    .adv_i    (cont && !adv_ni),
    .linear_i (linear_i),
    .seed_i   (addr_i[BURST_W-1:0]),
    .off_o    (off)
  );

  lane_ram #(.AW(MEM_AW), .LANES(LANES), .LANE_W(LANE_W)) u_ram (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (full_addr[MEM_AW-1:0]),
    .we_i    (lane_we),
    .re_i    (op == OP_READ),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slp_q    <= '0;
      base_q   <= '0;
      active_q <= 1'b0;
      drv_q    <= 1'b0;
    end else begin
      slp_q  <= {slp_q[0], sleep_i};
      base_q <= base_e;
      if (sleeping || op == OP_DESEL) active_q <= 1'b0;
      else if (start)                 active_q <= 1'b1;
      // first read out of a deselected state stays undriven
      drv_q <= (op == OP_READ) && active_q;
    end
  end

  assign drive_o = drv_q && !oe_ni;

  a_r7_write_tristates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|lane_we) |=> !drive_o);
  a_r6_deselect_tristates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleeping && strobe && !sel) |=> !drive_o);
  a_r8_first_read_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && !active_q) |=> !drive_o);
  a_r10_sleep_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleeping |=> (!drive_o && !active_q));
  a_r6_drive_needs_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_q |-> active_q);
  a_r2_processor_start_reads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p_start |-> lane_we == '0);
endmodule

// File: tb/sram_burst_ctrl_bench.sv
`timescale 1ns/1ps
module sram_burst_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [16:0] addr = '0;
  logic        ce1_n, ce2, ce3_n, adsp_n, adsc_n, adv_n, gw_n, bwe_n;
  logic [3:0]  bw_n;
  logic        oe_n = 1'b0, sleep = 1'b0, lin = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        drive;

  always #2.5 clk = ~clk;

  sram_burst_ctrl #(.MEM_AW(5)) u_sram_burst_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr),
    .ce1_ni(ce1_n), .ce2_i(ce2), .ce3_ni(ce3_n),
    .adsp_ni(adsp_n), .adsc_ni(adsc_n), .adv_ni(adv_n),
    .gw_ni(gw_n), .bwe_ni(bwe_n), .bw_ni(bw_n),
    .oe_ni(oe_n), .sleep_i(sleep), .linear_i(lin),
    .wdata_i(wdata), .rdata_o(rdata), .drive_o(drive)
  );

  typedef struct {
    int          due;
    logic [31:0] d;
    logic        dv;
    logic        chk_d;
    string       tag;
  } item_t;

  item_t       sb[$];
  logic [31:0] ref_mem [32];
  int          cyc = 0, total = 0, bad = 0;
  bit          done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: mid high phase, compare results due at this edge
  initial forever begin
    @(posedge clk);
    #1.25;
    while (sb.size() > 0 && sb[0].due == cyc) begin
      item_t it;
      it = sb.pop_front();
      total++;
      if (drive !== it.dv) begin
        bad++;
        $display("FAIL %s drive act=%0b exp=%0b", it.tag, drive, it.dv);
      end
      if (it.chk_d) begin
        total++;
        if (rdata !== it.d) begin
          bad++;
          $display("FAIL %s rdata act=%08h exp=%08h", it.tag, rdata, it.d);
        end
      end
    end
  end

  task automatic push(input logic [31:0] d, input logic dv, input logic cd, input string tag);
    item_t it;
    it.due = cyc + 1; it.d = d; it.dv = dv; it.chk_d = cd; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic go();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rest();
    ce1_n = 0; ce2 = 1; ce3_n = 0;
    adsp_n = 1; adsc_n = 1; adv_n = 1;
    gw_n = 1; bwe_n = 1; bw_n = 4'hF;
  endtask

  task automatic wr_c(input logic [16:0] a, input logic [31:0] d, input logic g,
                      input logic be, input logic [3:0] b, input bit apply, input string tag);
    rest(); adsc_n = 0; addr = a; wdata = d; gw_n = g; bwe_n = be; bw_n = b;
    adv_n = 0;  // ignored on the start edge (R3)
    if (apply)
      for (int l = 0; l < 4; l++)
        if (!g || (!be && !b[l])) ref_mem[a[4:0]][l*8 +: 8] = d[l*8 +: 8];
    push('0, 1'b0, 1'b0, tag);
    go();
  endtask

  task automatic rd_c(input logic [16:0] a, input logic dv, input string tag);
    rest(); adsc_n = 0; addr = a;
    push(ref_mem[a[4:0]], dv, 1'b1, tag);
    go();
  endtask

  task automatic step_adv(input logic av, input int ea, input string tag);
    rest(); adv_n = av;
    push(ref_mem[ea], 1'b1, 1'b1, tag);
    go();
  endtask

  initial begin
    rest();
    repeat (3) @(negedge clk);
    total++;
    if (rdata !== '0 || drive !== 1'b0) begin
      bad++;
      $display("FAIL R12 reset act=%08h/%0b exp=00000000/0", rdata, drive);
    end
    rst_n = 1;
    @(negedge clk);

    // R3 one-cycle controller writes
    wr_c(17'd4, 32'h11223344, 0, 1, 4'hF, 1, "R3 R7 write");
    wr_c(17'd8, 32'hAABBCCDD, 0, 1, 4'hF, 1, "R3 R7 write");
    rd_c(17'd4, 1, "R3 R5 read back");

    // R1/R6 deselect by ce2, R8 masked first read
    rest(); adsc_n = 0; ce2 = 0; push('0, 0, 0, "R1 R6 deselect ce2"); go();
    rd_c(17'd8, 0, "R8 first read masked");
    rd_c(17'd4, 1, "R8 second read driven");
    rest(); adsc_n = 0; ce3_n = 1; push('0, 0, 0, "R1 deselect ce3"); go();
    rd_c(17'd8, 0, "R8 masked again");
    rest(); adsp_n = 0; ce1_n = 1; addr = 17'd4;
    push(ref_mem[8], 1, 1, "R1 processor strobe ignored with ce1 high"); go();
    rest(); oe_n = 1; push(ref_mem[8], 0, 1, "R6 oe high gates drive"); go();
    oe_n = 0;

    // R2 processor strobe: read first, write next edge
    wr_c(17'd12, 32'h01010101, 0, 1, 4'hF, 1, "R3 write");
    rest(); adsp_n = 0; addr = 17'd12; gw_n = 0; wdata = 32'hDEAD0001;
    push(ref_mem[12], 1, 1, "R2 start is read"); go();
    rest(); gw_n = 0; wdata = 32'hCAFEF00D; ref_mem[12] = 32'hCAFEF00D;
    push('0, 0, 0, "R2 R7 second-edge write"); go();
    rd_c(17'd12, 1, "R2 write landed");

    // R4 byte lanes
    wr_c(17'd12, 32'hFFFFFFFF, 1, 0, 4'b1010, 1, "R4 lanes 0,2");
    rd_c(17'd12, 1, "R4 partial bytes");
    rest(); adsc_n = 0; addr = 17'd12; bwe_n = 0; bw_n = 4'hF; wdata = '0;
    push(ref_mem[12], 1, 1, "R4 no lane selected is read"); go();
    rest(); adsc_n = 0; addr = 17'd12; bw_n = 4'h0; wdata = '0;
    push(ref_mem[12], 1, 1, "R4 bwe high is read"); go();

    // R11 both strobes
    rest(); adsp_n = 0; adsc_n = 0; addr = 17'd8; gw_n = 0; wdata = '0;
    push(ref_mem[8], 1, 1, "R11 processor wins"); go();
    rd_c(17'd8, 1, "R11 data kept");

    // R9 bursts
    for (int i = 0; i < 4; i++)
      wr_c(17'(16 + i), 32'hB0000010 + 32'(i), 0, 1, 4'hF, 1, "R3 fill");
    lin = 0;
    rest(); adsp_n = 0; addr = 17'd18; push(ref_mem[18], 1, 1, "R9 il first"); go();
    step_adv(0, 19, "R9 il second");
    step_adv(0, 16, "R9 il third");
    step_adv(0, 17, "R9 il fourth");
    step_adv(1, 17, "R9 il hold");
    lin = 1;
    rd_c(17'd19, 1, "R9 lin first");
    step_adv(0, 16, "R9 lin wrap");
    step_adv(0, 17, "R9 lin third");
    step_adv(0, 18, "R9 lin fourth");
    lin = 0;
    wr_c(17'd17, 32'h77770000, 0, 1, 4'hF, 1, "R3 burst start");
    rest(); adv_n = 0; gw_n = 0; wdata = 32'h77771111; ref_mem[16] = 32'h77771111;
    push('0, 0, 0, "R9 burst write step"); go();
    rd_c(17'd16, 1, "R9 burst write addr");
    rd_c(17'd17, 1, "R9 burst start addr");

    // R10 sleep
    wr_c(17'd20, 32'h5A5A5A5A, 0, 1, 4'hF, 1, "R3 write");
    sleep = 1; rest(); go(); go();
    wr_c(17'd20, 32'h0BAD0BAD, 0, 1, 4'hF, 0, "R10 write while asleep");
    rd_c(17'd20, 0, "R10 no drive asleep");
    sleep = 0; rest(); go(); go();
    rd_c(17'd20, 0, "R10 retained, first read masked");
    rd_c(17'd20, 1, "R10 driven after wake");

    rest(); go(); go();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule